// File: doc/BRIEF.md
# Four-Lane Striped Transmit Framer

This block accepts 32-bit words from a host over a ready/valid handshake and spreads each word across four parallel byte-wide transmit lanes. A last-word flag from the host marks the frame boundary. Each lane carries a 10-bit word per byte clock. The word holds a two-symbol pair, a control bit that separates line codes from data, and an optional parity bit. All four lanes always carry the same kind of item in the same cycle. This lets the receiving side realign the lanes on the start delimiter.

For each frame, the framer places a start pair on every lane, then the striped data bytes, then a closing pair. Between frames it fills the lanes with idle pairs for a programmable minimum gap, and the gap never drops below four pairs. It checks the number of words in each frame. A frame that is too short, or one that runs past the length limit, is closed with an abort pair instead of the ending delimiter, and an error flag is raised in that same cycle. The host is stalled whenever the framer inserts line codes of its own.

Top module: `stripe_framer`

## Requirements
- R1: One cycle after a host handshake on a data word, all four lanes carry it at once with control bit 0. Lane i carries s_data[8i+7:8i], so lane 0 gets bits 7:0 and lane 3 gets bits 31:24.
- R2: Every frame opens with a start pair (code 8'h12, control bit 1) on all lanes. This pair comes in the cycle just before the first data word of the frame.
- R3: A frame of MIN_LEN (3) to MAX_LEN (4500) words is closed by one ending-delimiter pair (code 8'h34, control 1) on all lanes, in the cycle after its last data word.
- R4: A frame with fewer than MIN_LEN words still sends its data words. It is then closed by an abort pair (code 8'h55, control 1) instead of the ending delimiter, and len_err is high in exactly that cycle.
- R5: In a frame that reaches MAX_LEN words, the next word is accepted but not sent. An abort pair with len_err high takes its place. Every further word up to and including the one flagged last is accepted and dropped, and the lanes carry only idle pairs meanwhile.
- R6: Idle pairs use code 8'h77 with control 1. After an ending delimiter or abort, at least G idle cycles pass before the next start pair, and exactly G when the host is already waiting. G is 8 when cfg_gap is 0, 4 when cfg_gap is 1 to 3, and cfg_gap otherwise.
- R7: Lane word layout: bit 9 is parity, bit 8 is control, bits 7:4 are the first symbol and bits 3:0 the second. With par_en high, the parity bit makes the number of ones in the 10-bit word odd. With par_en low, it is 0.
- R8: s_ready is low while ending delimiters and gap idles are emitted, and low before each start pair. It is high from the start pair through the body of the frame.
- R9: During reset, every lane holds the idle word 10'h177, and s_ready and len_err are 0.
- R10: If s_valid drops inside a frame, the lanes carry idle pairs and the frame stays open. The word count and the data order are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | 1 | Enables parity generation on the lanes |
| cfg_gap | input | 4 | Minimum idle pairs between frames (0 selects the default) |
| s_valid | input | 1 | Host word valid |
| s_ready | output | 1 | Framer accepts a host word |
| s_data | input | 32 | Host word |
| s_last | input | 1 | Host word is the last of its frame |
| lane_o | output | 4x10 | Lane words, lane 0 in bits 9:0 |
| len_err | output | 1 | Frame length violation, coincident with the abort pair |

## Verification
Two events can land in the same cycle: the length overrun and the end of the frame. This happens when the word that exceeds the limit is also the one flagged last. The bench sends a frame exactly one word over the limit. It expects the abort to replace that word, with no drain phase and an exact gap before the next start pair. It also sends a longer overrun, which must drain quietly before the gap is counted. Separately, a one-word frame makes the short-length abort follow the last data word directly. Each item the framer emits on the lanes is compared, together with len_err, against a queue the driver fills from the requirements.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int unsigned LANE_W = 10;

    localparam logic [7:0] PAIR_IDLE  = 8'h77;
    localparam logic [7:0] PAIR_START = 8'h12;
    localparam logic [7:0] PAIR_END   = 8'h34;
    localparam logic [7:0] PAIR_ABORT = 8'h55;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_START,
        LK_END,
        LK_ABORT,
        LK_DATA
    } lane_kind_e;

    typedef enum logic [2:0] {
        FS_GAP,
        FS_WAIT,
        FS_BODY,
        FS_CLOSE,
        FS_REJECT,
        FS_DRAIN
    } fsm_e;

    typedef struct packed {
        logic       par;
        logic       ctrl;
        logic [7:0] pair;
    } lane_word_t;

    localparam lane_word_t IDLE_WORD = '{par: 1'b0, ctrl: 1'b1, pair: PAIR_IDLE};

    function automatic lane_word_t encode_lane(lane_kind_e kind,
                                               logic [7:0] dbyte,
                                               logic par_en);
        lane_word_t w;
        w.ctrl = 1'b1;
        case (kind)
            LK_START: w.pair = PAIR_START;
            LK_END:   w.pair = PAIR_END;
            LK_ABORT: w.pair = PAIR_ABORT;
            LK_DATA: begin
                w.ctrl = 1'b0;
                w.pair = dbyte;
            end
            default:  w.pair = PAIR_IDLE;
        endcase
        w.par = par_en ? ~^{w.ctrl, w.pair} : 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/fr_gap_sel.sv
module fr_gap_sel #(
    parameter int unsigned GAP_W   = 4,
    parameter int unsigned DEF_GAP = 8,
    parameter int unsigned MIN_GAP = 4
) (
    input  logic [GAP_W-1:0] cfg_gap,
    output logic [GAP_W-1:0] eff_gap
);
    always_comb begin
        if (cfg_gap == '0)
            eff_gap = GAP_W'(DEF_GAP);
        else if (32'(cfg_gap) < MIN_GAP)
            eff_gap = GAP_W'(MIN_GAP);
        else
            eff_gap = cfg_gap;
    end
endmodule

// File: rtl/fr_frame_ctrl.sv
module fr_frame_ctrl
    import fr_pkg::*;
#(
    parameter int unsigned MIN_LEN = 3,
    parameter int unsigned MAX_LEN = 4500,
    parameter int unsigned GAP_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_valid,
    input  logic             s_last,
    input  logic [GAP_W-1:0] eff_gap,
    output logic             s_ready,
    output lane_kind_e       kind,
    output logic             err_set
);
    localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

    fsm_e             state, nstate;
    logic [CNT_W-1:0] wcnt, nwcnt;
    logic [GAP_W-1:0] gcnt, ngcnt;

    always_comb begin
        nstate  = state;
        nwcnt   = wcnt;
        ngcnt   = gcnt;
        kind    = LK_IDLE;
        err_set = 1'b0;
        s_ready = 1'b0;
        case (state)
            FS_GAP: begin
                ngcnt = gcnt + 1'b1;
                if (32'(gcnt) + 1 >= 32'(eff_gap)) begin
                    nstate = FS_WAIT;
                    ngcnt  = '0;
                end
            end
            FS_WAIT: begin
                if (s_valid) begin
                    kind   = LK_START;
                    nstate = FS_BODY;
                    nwcnt  = '0;
                end
            end
            FS_BODY: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    if (wcnt == CNT_W'(MAX_LEN)) begin
                        kind    = LK_ABORT;
                        err_set = 1'b1;
                        ngcnt   = '0;
                        nstate  = s_last ? FS_GAP : FS_DRAIN;
                    end else begin
                        kind  = LK_DATA;
                        nwcnt = wcnt + 1'b1;
                        if (s_last)
                            nstate = (32'(wcnt) + 1 < MIN_LEN) ? FS_REJECT : FS_CLOSE;
                    end
                end
            end
            FS_CLOSE: begin
                kind   = LK_END;
                nstate = FS_GAP;
                ngcnt  = '0;
            end
            FS_REJECT: begin
                kind    = LK_ABORT;
                err_set = 1'b1;
                nstate  = FS_GAP;
                ngcnt   = '0;
            end
            FS_DRAIN: begin
                s_ready = 1'b1;
                if (s_valid && s_last) begin
                    nstate = FS_GAP;
                    ngcnt  = '0;
                end
            end
            default: nstate = FS_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_GAP;
            wcnt  <= '0;
            gcnt  <= '0;
        end else begin
            state <= nstate;
            wcnt  <= nwcnt;
            gcnt  <= ngcnt;
        end
    end

    // R5
    wcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(wcnt) <= MAX_LEN);

    // R5
    drain_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == FS_DRAIN) |-> (kind == LK_IDLE));

    // R8
    wait_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == LK_START) |=> s_ready);

endmodule

// File: rtl/fr_lane_enc.sv
module fr_lane_enc
    import fr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_kind_e        kind,
    input  logic [7:0]        dbyte,
    input  logic              par_en,
    output logic [LANE_W-1:0] lane_q
);
    lane_word_t nxt;

    always_comb nxt = encode_lane(kind, dbyte, par_en);

    always_ff @(posedge clk) begin
        if (rst)
            lane_q <= IDLE_WORD;
        else
            lane_q <= nxt;
    end

    // R7
    par_off_chk: assert property (@(posedge clk) disable iff (rst)
        !par_en |=> (lane_q[LANE_W-1] == 1'b0));
endmodule

// File: rtl/stripe_framer.sv
module stripe_framer
    import fr_pkg::*;
#(
    parameter int unsigned LANES   = 4,
    parameter int unsigned MIN_LEN = 3,
    parameter int unsigned MAX_LEN = 4500,
    parameter int unsigned GAP_W   = 4,
    parameter int unsigned DEF_GAP = 8,
    parameter int unsigned MIN_GAP = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         par_en,
    input  logic [GAP_W-1:0]             cfg_gap,
    input  logic                         s_valid,
    output logic                         s_ready,
    input  logic [LANES*8-1:0]           s_data,
    input  logic                         s_last,
    output logic [LANES-1:0][LANE_W-1:0] lane_o,
    output logic                         len_err
);
    logic [GAP_W-1:0] eff_gap;
    lane_kind_e       kind;
    logic             err_set;

    fr_gap_sel #(
        .GAP_W  (GAP_W),
        .DEF_GAP(DEF_GAP),
        .MIN_GAP(MIN_GAP)
    ) u_gap (
        .cfg_gap(cfg_gap),
        .eff_gap(eff_gap)
    );

    fr_frame_ctrl #(
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN),
        .GAP_W  (GAP_W)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .s_valid(s_valid),
        .s_last (s_last),
        .eff_gap(eff_gap),
        .s_ready(s_ready),
        .kind   (kind),
        .err_set(err_set)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fr_lane_enc u_enc (
            .clk   (clk),
            .rst   (rst),
            .kind  (kind),
            .dbyte (s_data[8*i +: 8]),
            .par_en(par_en),
            .lane_q(lane_o[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            len_err <= 1'b0;
        else
            len_err <= err_set;
    end

    logic [LANES-1:0] ctrl_bits;
    always_comb
        for (int i = 0; i < LANES; i++) ctrl_bits[i] = lane_o[i][8];

    // R1
    lanes_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits == '0) || (ctrl_bits == '1));

    // R4
    err_marks_abort_chk: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (lane_o[0][8] && lane_o[LANES-1][7:0] == PAIR_ABORT));

    // R2
    start_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_o[0][8] && lane_o[0][7:0] == PAIR_START)
            |-> ($past(lane_o[0][7:0]) == PAIR_IDLE));

    // R8
    end_stalls_host_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_o[0][8] && lane_o[0][7:0] == PAIR_END) |-> !s_ready);

endmodule

// File: tb/tb_stripe_framer.sv
`timescale 1ns/1ps
module tb_stripe_framer;
    localparam int MIN_LEN = 3;
    localparam int MAX_LEN = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        par_en = 1'b1;
    logic [3:0]  cfg_gap = 4'd0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        s_last = 1'b0;
    logic [3:0][9:0] lane_o;
    logic        len_err;

    always #10 clk = ~clk;

    stripe_framer #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) dut (
        .clk(clk), .rst(rst), .par_en(par_en), .cfg_gap(cfg_gap),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_last(s_last), .lane_o(lane_o), .len_err(len_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit mon_on = 0;

    logic [39:0] exp_vec[$];
    bit          exp_err[$];
    string       exp_tag[$];

    int gap_exp   = 8;
    bit gap_exact = 0;
    bit after_end = 0;
    int gap_run   = 0;

    function automatic logic [9:0] lw(bit c, logic [7:0] p, bit pe);
        return {pe ? ~^{c, p} : 1'b0, c, p};
    endfunction

    function automatic logic [39:0] ctl_vec(logic [7:0] p, bit pe);
        return {4{lw(1'b1, p, pe)}};
    endfunction

    function automatic logic [39:0] dat_vec(logic [31:0] w, bit pe);
        logic [39:0] v;
        for (int i = 0; i < 4; i++) v[i*10 +: 10] = lw(1'b0, w[i*8 +: 8], pe);
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(logic [39:0] v, bit e, string tag);
        exp_vec.push_back(v);
        exp_err.push_back(e);
        exp_tag.push_back(tag);
    endtask

    // Monitor: compares every non-idle lane item with the scoreboard
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            logic [39:0] v;
            v = lane_o;
            if (v[8] && v[7:0] == 8'h77) begin
                // R6 idle pairs on all lanes, no error
                check(v == ctl_vec(8'h77, 1'b0) && !len_err, "R6 idle word",
                      {23'b0, len_err, v}, {24'b0, ctl_vec(8'h77, 1'b0)});
                if (after_end) gap_run++;
            end else begin
                if (exp_vec.size() == 0) begin
                    check(1'b0, "R1 unexpected lane item", {24'b0, v}, 64'b0);
                end else begin
                    logic [39:0] ev;
                    bit ee;
                    string et;
                    ev = exp_vec.pop_front();
                    ee = exp_err.pop_front();
                    et = exp_tag.pop_front();
                    check(v == ev && len_err == ee, et,
                          {23'b0, len_err, v}, {23'b0, ee, ev});
                end
                if (v[8] && v[7:0] == 8'h12) begin
                    // R8 body open: host accepted
                    check(s_ready == 1'b1, "R8 ready during start", {63'b0, s_ready}, 64'd1);
                    if (after_end) begin
                        if (gap_exact)
                            check(gap_run == gap_exp, "R6 exact gap", 64'(gap_run), 64'(gap_exp));
                        else
                            check(gap_run >= gap_exp, "R6 minimum gap", 64'(gap_run), 64'(gap_exp));
                    end
                    after_end = 0;
                end
                if (v[8] && v[7:0] == 8'h34)
                    check(s_ready == 1'b0, "R8 ready low at end delimiter", {63'b0, s_ready}, 64'd0);
                if (v[8] && (v[7:0] == 8'h34 || v[7:0] == 8'h55)) begin
                    after_end = 1;
                    gap_run   = 0;
                end
            end
        end
    end

    // Driver: fills the scoreboard, then presents the words
    task automatic send_frame(int n, logic [31:0] seed, bit b2b, int stall_at);
        bit pe;
        pe = par_en;
        gap_exact = b2b;
        push(ctl_vec(8'h12, pe), 1'b0, "R2 start pair");
        for (int k = 0; k < n && k < MAX_LEN; k++)
            push(dat_vec(seed ^ (32'(k) * 32'h9E3779B9), pe), 1'b0, "R1 striped data");
        if (n > MAX_LEN)
            push(ctl_vec(8'h55, pe), 1'b1, "R5 overlong abort");
        else if (n < MIN_LEN)
            push(ctl_vec(8'h55, pe), 1'b1, "R4 short abort");
        else
            push(ctl_vec(8'h34, pe), 1'b0, "R3 end delimiter");
        for (int k = 0; k < n; k++) begin
            if (k == stall_at) begin
                s_valid = 1'b0;   // R10 host bubble inside frame
                repeat (3) @(negedge clk);
            end
            s_valid = 1'b1;
            s_data  = seed ^ (32'(k) * 32'h9E3779B9);
            s_last  = (k == n - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic quiet(int n);
        s_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(lane_o == ctl_vec(8'h77, 1'b0), "R9 reset lanes", {24'b0, lane_o}, {24'b0, ctl_vec(8'h77, 1'b0)});
        check(s_ready == 1'b0, "R9 reset ready", {63'b0, s_ready}, 64'd0);
        check(len_err == 1'b0, "R9 reset len_err", {63'b0, len_err}, 64'd0);
        rst = 1'b0;
        mon_on = 1;
        @(negedge clk);

        gap_exp = 8;
        send_frame(5, 32'hA1B2C3D4, 1'b0, -1);    // R1 R2 R3
        send_frame(3, 32'h01020304, 1'b1, -1);    // R3 minimum length, R6 default gap
        send_frame(1, 32'hFFFF0000, 1'b1, -1);    // R4 one word
        send_frame(2, 32'h5A5A5A5A, 1'b1, -1);    // R4 two words
        quiet(20);
        par_en = 1'b0;                            // R7 parity off
        send_frame(MAX_LEN, 32'h13572468, 1'b0, -1);      // R3 at the limit
        send_frame(MAX_LEN + 1, 32'hCAFEF00D, 1'b1, -1);  // R5 overrun on last word
        send_frame(MAX_LEN + 4, 32'h0BADBEEF, 1'b1, -1);  // R5 overrun with drain
        send_frame(4, 32'h11111111, 1'b0, -1);    // drain idles lengthen gap
        quiet(20);
        cfg_gap = 4'd2;                           // R6 clamp to four
        gap_exp = 4;
        send_frame(4, 32'h22222222, 1'b0, -1);
        send_frame(4, 32'h33333333, 1'b1, -1);
        quiet(20);
        cfg_gap = 4'd10;                          // R6 programmed gap
        gap_exp = 10;
        par_en = 1'b1;
        send_frame(6, 32'h44444444, 1'b0, -1);
        send_frame(7, 32'h87654321, 1'b1, 3);     // R10 stall mid-frame
        send_frame(3, 32'h0F0F0F0F, 1'b1, 1);     // R10 stall, minimum length
        quiet(30);
        check(exp_vec.size() == 0, "R3 scoreboard drained", 64'(exp_vec.size()), 64'd0);
        finish_run();
    end
endmodule